// File: doc/BRIEF.md
# Two-Bit Chainable Arithmetic Slice

This block is a 2-bit arithmetic element meant to be placed side by side to build wider datapaths. A 3-bit operation code selects what the slice does with its two operands and its carry input. It can add, subtract, add or subtract under a run-time control pin, count up or down in a registered counter, or compare its operands (greater-or-equal, not-equal, less-or-equal). Every result that crosses slice boundaries travels on the carry chain. The carry output of one slice feeds the carry input of the next, more significant slice.

Each slice also exports a slice-level carry-generate and carry-propagate pair. Carry-out always equals `gen_o | (prop_o & cin_i)` in every mode, so a lookahead unit can span several slices without knowing the operation. Subtraction adds the inverted subtrahend. The +1 enters at the carry input of the lowest slice. Comparisons pass an "upper part already decided or still tied" status from lower to upper slices, so the carry-out of the top slice holds the full-width comparison. In counting modes the lowest slice gets carry-in 1, and each slice passes a wrap indication up as its carry-out.

The element has no streaming data interface. Its pins are plain control and data pins, and arithmetic results are combinational. Only the counter holds state. It resets asynchronously to zero on an active-low reset.

Top module: `arith2_slice`

## Requirements
- R1: With `op_i` = 0 (add), `{cout_o, res_o}` equals `a_i + b_i + cin_i`.
- R2: With `op_i` = 1 (subtract), `{cout_o, res_o}` equals `a_i + ~b_i + cin_i`. With `cin_i` = 1, `res_o` is `a_i - b_i` modulo 4 and `cout_o` is 1 exactly when `a_i >= b_i`.
- R3: With `op_i` = 2 (dynamic), the slice behaves as R1 when `dyn_sub_i` = 0 and as R2 when `dyn_sub_i` = 1.
- R4: In every mode, `cout_o` equals `gen_o | (prop_o & cin_i)`. In add, subtract and compare modes, `gen_o` = g1 | (p1 & g0) and `prop_o` = p1 & p0, where gi = xi & yi and pi = xi ^ yi. The operands (x, y) are (a, b) for add, (a, ~b) for subtract and greater-or-equal, and (b, ~a) for less-or-equal.
- R5: With `op_i` = 3 (count up), each rising clock edge with `cnt_en_i` = 1 and `cin_i` = 1 adds 1 to `cnt_o`, wrapping from 3 to 0. `cout_o` is `cin_i` AND (`cnt_o` = 3).
- R6: With `op_i` = 4 (count down), each rising edge with `cnt_en_i` = 1 and `cin_i` = 1 subtracts 1 from `cnt_o`, wrapping from 0 to 3. `cout_o` is `cin_i` AND (`cnt_o` = 0).
- R7: `cnt_o` holds its value on any edge where the op is not 3 or 4, or `cnt_en_i` = 0, or `cin_i` = 0. In count modes `res_o` shows `cnt_o`.
- R8: With `op_i` = 5 (greater-or-equal), `cout_o` = (A > B) | (A == B & `cin_i`) and `res_o` = 0.
- R9: With `op_i` = 6 (not-equal), `cout_o` = (A != B) | `cin_i`, `gen_o` = (A != B), `prop_o` = (A == B), and `res_o` = 0.
- R10: With `op_i` = 7 (less-or-equal), `cout_o` = (A < B) | (A == B & `cin_i`) and `res_o` = 0.
- R11: While `rst_ni` is low, `cnt_o` is 0.
- R12: Slices chained carry-out to carry-in give wider arithmetic. With carry-in 0 into the lowest slice, add gives the full sum. With carry-in 1, subtract gives the difference. The top carry-out gives full-width GE/LE (lowest carry-in 1) and NE (lowest carry-in 0). In count modes the concatenated counters count as one wide counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the counter |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (see requirements) |
| dyn_sub_i | input | 1 | In op 2: 0 adds, 1 subtracts |
| cnt_en_i | input | 1 | Count enable |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| cin_i | input | 1 | Carry / status from the less significant slice |
| res_o | output | W | Sum, difference, or count value |
| cout_o | output | 1 | Carry / status to the more significant slice |
| gen_o | output | 1 | Slice carry-generate |
| prop_o | output | 1 | Slice carry-propagate |
| cnt_o | output | W | Registered counter value |

## Verification
Arithmetic, compare, generate and propagate results are combinational. The bench samples them one time unit after the inputs settle, with no clock edge counted. A counter result is due on the first rising edge after enable and carry-in are applied. The bench drives count inputs at a falling edge and checks the new value at the next falling edge, one register stage later. A chain of slices is checked the same way: wide sums and compares are sampled as settled combinational values, and the wide counter is checked at every falling edge after each counting edge.

// File: rtl/arith2_pkg.sv
package arith2_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_ADDSUB = 3'd2,
    OP_UP     = 3'd3,
    OP_DOWN   = 3'd4,
    OP_GE     = 3'd5,
    OP_NE     = 3'd6,
    OP_LE     = 3'd7
  } op_e;

  typedef struct packed {
    logic sum_path;  // result comes from the ripple adder
    logic res_zero;  // compare: arithmetic result suppressed
    logic is_ne;     // not-equal path
    logic is_cnt;    // counter path
    logic cnt_down;  // count direction
    logic swap;      // x=b, y=a
    logic inv_y;     // invert second operand
  } ctl_t;

endpackage

// File: rtl/arith2_opsel.sv
module arith2_opsel
  import arith2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [2:0]   op_i,
  input  logic         dyn_sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output ctl_t         ctl_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);

  always_comb begin
    ctl_o = '0;
    unique case (op_e'(op_i))
      OP_ADD:    ctl_o.sum_path = 1'b1;
      OP_SUB: begin
        ctl_o.sum_path = 1'b1;
        ctl_o.inv_y    = 1'b1;
      end
      OP_ADDSUB: begin
        ctl_o.sum_path = 1'b1;
        ctl_o.inv_y    = dyn_sub_i;
      end
      OP_UP:     ctl_o.is_cnt = 1'b1;
      OP_DOWN: begin
        ctl_o.is_cnt   = 1'b1;
        ctl_o.cnt_down = 1'b1;
      end
      OP_GE: begin
        ctl_o.sum_path = 1'b1;
        ctl_o.res_zero = 1'b1;
        ctl_o.inv_y    = 1'b1;
      end
      OP_NE: begin
        ctl_o.is_ne    = 1'b1;
        ctl_o.res_zero = 1'b1;
      end
      OP_LE: begin
        ctl_o.sum_path = 1'b1;
        ctl_o.res_zero = 1'b1;
        ctl_o.swap     = 1'b1;
        ctl_o.inv_y    = 1'b1;
      end
      default:   ctl_o = '0;
    endcase
  end

  logic [W-1:0] y_raw;

  assign x_o   = ctl_o.swap ? b_i : a_i;
  assign y_raw = ctl_o.swap ? a_i : b_i;
  assign y_o   = y_raw ^ {W{ctl_o.inv_y}};

endmodule

// File: rtl/arith2_ripple.sv
module arith2_ripple #(
  parameter int W = 2
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         gen_o,
  output logic         prop_o
);

  logic [W-1:0] g;
  logic [W-1:0] p;
  logic [W:0]   c;
  logic [W-1:0] gacc;
  logic [W-1:0] pacc;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i]     = x_i[i] & y_i[i];
    assign p[i]     = x_i[i] ^ y_i[i];
    assign c[i+1]   = g[i] | (p[i] & c[i]);
    assign sum_o[i] = p[i] ^ c[i];
    if (i == 0) begin : g_first
      assign gacc[i] = g[i];
      assign pacc[i] = p[i];
    end else begin : g_rest
      assign gacc[i] = g[i] | (p[i] & gacc[i-1]);
      assign pacc[i] = p[i] & pacc[i-1];
    end
  end

  assign cout_o = c[W];
  assign gen_o  = gacc[W-1];
  assign prop_o = pacc[W-1];

endmodule

// File: rtl/arith2_counter.sv
module arith2_counter #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] cnt_o,
  output logic         at_limit_o
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= down_i ? (cnt_q - ONE) : (cnt_q + ONE);
    end
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = down_i ? (cnt_q == '0) : (cnt_q == MAXV);

endmodule

// File: rtl/arith2_slice.sv
module arith2_slice
  import arith2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic         dyn_sub_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         gen_o,
  output logic         prop_o,
  output logic [W-1:0] cnt_o
);

  ctl_t         ctl;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W-1:0] sum;
  logic         rc_cout;
  logic         rc_gen;
  logic         rc_prop;
  logic [W-1:0] cnt;
  logic         at_limit;
  logic         ne;

  arith2_opsel #(.W(W)) u_opsel (
    .op_i      (op_i),
    .dyn_sub_i (dyn_sub_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .ctl_o     (ctl),
    .x_o       (x),
    .y_o       (y)
  );

  arith2_ripple #(.W(W)) u_ripple (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (cin_i),
    .sum_o  (sum),
    .cout_o (rc_cout),
    .gen_o  (rc_gen),
    .prop_o (rc_prop)
  );

  arith2_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (ctl.is_cnt & cnt_en_i & cin_i),
    .down_i     (ctl.cnt_down),
    .cnt_o      (cnt),
    .at_limit_o (at_limit)
  );

  assign ne    = (a_i != b_i);
  assign cnt_o = cnt;

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    gen_o  = 1'b0;
    prop_o = 1'b0;
    if (ctl.sum_path) begin
      res_o  = ctl.res_zero ? '0 : sum;
      cout_o = rc_cout;
      gen_o  = rc_gen;
      prop_o = rc_prop;
    end else if (ctl.is_ne) begin
      cout_o = ne | cin_i;
      gen_o  = ne;
      prop_o = ~ne;
    end else if (ctl.is_cnt) begin
      res_o  = cnt;
      cout_o = cin_i & at_limit;
      prop_o = at_limit;
    end
  end

endmodule

// File: rtl/arith2_slice_chk.sv
module arith2_slice_chk #(
  parameter int W = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   op_i,
  input logic         dyn_sub_i,
  input logic         cnt_en_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic         gen_o,
  input logic         prop_o,
  input logic [W-1:0] cnt_o
);

  logic [W:0] add_ref;
  logic       stepping;

  assign add_ref  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign stepping = ((op_i == 3'd3) || (op_i == 3'd4)) && cnt_en_i && cin_i;

  a_r1_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |-> ({cout_o, res_o} == add_ref));

  a_r2_sub_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && cin_i) |-> (cout_o == (a_i >= b_i)));

  a_r3_dyn_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !dyn_sub_i) |-> ({cout_o, res_o} == add_ref));

  a_r4_lookahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_o == (gen_o | (prop_o & cin_i)));

  a_r5_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && cnt_en_i && cin_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

  a_r6_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && cnt_en_i && cin_i) |=> (cnt_o == W'($past(cnt_o) - 1'b1)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stepping |=> $stable(cnt_o));

  a_r8_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |-> (cout_o == ((a_i > b_i) || (a_i == b_i && cin_i)) && res_o == '0));

  a_r9_ne: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6) |-> (cout_o == ((a_i != b_i) || cin_i) && res_o == '0));

  a_r10_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> (cout_o == ((a_i < b_i) || (a_i == b_i && cin_i)) && res_o == '0));

  always_comb begin
    if (!rst_ni) begin
      a_r11_reset_zero: assert (cnt_o == '0);
    end
  end

endmodule

bind arith2_slice arith2_slice_chk #(.W(W)) u_chk (.*);

// File: tb/arith2_slice_tb.sv
module arith2_slice_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 2;
  localparam int NS = 4;
  localparam int CW = W * NS;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // single slice
  logic [2:0]   op;
  logic         dyn, en, cin;
  logic [W-1:0] a, b;
  logic [W-1:0] res, cnt;
  logic         cout, gen, prop;

  arith2_slice #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .dyn_sub_i(dyn), .cnt_en_i(en),
    .a_i(a), .b_i(b), .cin_i(cin), .res_o(res), .cout_o(cout),
    .gen_o(gen), .prop_o(prop), .cnt_o(cnt)
  );

  // chain of slices
  logic [2:0]    ch_op;
  logic          ch_en;
  logic          ch_c0;
  logic [CW-1:0] ch_a, ch_b, ch_res, ch_cnt;
  logic [NS:0]   ch_c;
  logic [NS-1:0] ch_g, ch_p;

  assign ch_c[0] = ch_c0;

  for (genvar k = 0; k < NS; k++) begin : g_chain
    arith2_slice #(.W(W)) u_chain (
      .clk_i(clk), .rst_ni(rst_n), .op_i(ch_op), .dyn_sub_i(1'b0),
      .cnt_en_i(ch_en), .a_i(ch_a[W*k +: W]), .b_i(ch_b[W*k +: W]),
      .cin_i(ch_c[k]), .res_o(ch_res[W*k +: W]), .cout_o(ch_c[k+1]),
      .gen_o(ch_g[k]), .prop_o(ch_p[k]), .cnt_o(ch_cnt[W*k +: W])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int bitgp(input int x, input int y, input bit want_g);
    int g0, g1, p0, p1;
    g0 = (x & y) & 1;       g1 = ((x & y) >> 1) & 1;
    p0 = (x ^ y) & 1;       p1 = ((x ^ y) >> 1) & 1;
    return want_g ? (g1 | (p1 & g0)) : (p1 & p0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    finish_run();
  end

  // single-slice combinational sweep
  task automatic sweep_single();
    for (int o = 0; o < 8; o++) begin
      if (o == 3 || o == 4) continue;
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int ic = 0; ic < 2; ic++)
            for (int id = 0; id < 2; id++) begin
              int x, y, tot, ecout, eres;
              bit use_sum;
              op = 3'(o); a = 2'(ia); b = 2'(ib); cin = 1'(ic); dyn = 1'(id);
              #1;
              use_sum = 1'b1;
              x = ia; y = ib;
              if (o == 1 || o == 5 || (o == 2 && id == 1)) y = 3 - ib;
              if (o == 7) begin x = ib; y = 3 - ia; end
              tot = x + y + ic;
              eres = tot & 3;
              ecout = tot >> 2;
              case (o)
                0: begin chk("R1 add res", res, eres); chk("R1 add cout", cout, ecout); end
                1: begin
                  chk("R2 sub res", res, eres); chk("R2 sub cout", cout, ecout);
                  if (ic == 1) begin
                    chk("R2 sub diff", res, (ia - ib) & 3);
                    chk("R2 sub ge", cout, int'(ia >= ib));
                  end
                end
                2: begin
                  chk(id ? "R3 dyn sub res" : "R3 dyn add res", res, eres);
                  chk("R3 dyn cout", cout, ecout);
                end
                5: begin
                  chk("R8 ge cout", cout, int'(ia > ib || (ia == ib && ic == 1)));
                  chk("R8 ge res", res, 0);
                end
                6: begin
                  use_sum = 1'b0;
                  chk("R9 ne cout", cout, int'(ia != ib || ic == 1));
                  chk("R9 ne gen", gen, int'(ia != ib));
                  chk("R9 ne prop", prop, int'(ia == ib));
                  chk("R9 ne res", res, 0);
                end
                default: begin
                  chk("R10 le cout", cout, int'(ia < ib || (ia == ib && ic == 1)));
                  chk("R10 le res", res, 0);
                end
              endcase
              if (use_sum) begin
                chk("R4 gen", gen, bitgp(x, y, 1'b1));
                chk("R4 prop", prop, bitgp(x, y, 1'b0));
              end
              chk("R4 cout=gen|prop&cin", cout, int'(gen | (prop & cin)));
            end
    end
  endtask

  // chained combinational sweep
  task automatic sweep_chain();
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib += 7) begin
        int gt, pt;
        ch_a = CW'(ia); ch_b = CW'(ib);
        ch_op = 3'd0; ch_c0 = 1'b0; #1;
        chk("R12 wide add", int'({ch_c[NS], ch_res}), ia + ib);
        gt = 0; pt = 1;
        for (int k = 0; k < NS; k++) begin
          gt = ch_g[k] | (ch_p[k] & gt);
          pt = ch_p[k] & pt;
        end
        chk("R12 R4 wide lookahead", int'(ch_c[NS]), gt | (pt & int'(ch_c0)));
        ch_op = 3'd1; ch_c0 = 1'b1; #1;
        chk("R12 wide sub", int'(ch_res), (ia - ib) & 255);
        chk("R12 wide sub borrow", int'(ch_c[NS]), int'(ia >= ib));
        ch_op = 3'd5; ch_c0 = 1'b1; #1;
        chk("R12 R8 wide ge", int'(ch_c[NS]), int'(ia >= ib));
        ch_op = 3'd7; ch_c0 = 1'b1; #1;
        chk("R12 R10 wide le", int'(ch_c[NS]), int'(ia <= ib));
        ch_op = 3'd6; ch_c0 = 1'b0; #1;
        chk("R12 R9 wide ne", int'(ch_c[NS]), int'(ia != ib));
      end
    // equal operands explicitly
    ch_a = 8'hA5; ch_b = 8'hA5;
    ch_op = 3'd6; ch_c0 = 1'b0; #1;
    chk("R12 R9 wide ne equal", int'(ch_c[NS]), 0);
  endtask

  initial begin : main
    op = 3'd0; dyn = 1'b0; en = 1'b0; cin = 1'b0; a = '0; b = '0;
    ch_op = 3'd0; ch_en = 1'b0; ch_c0 = 1'b0; ch_a = '0; ch_b = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset cnt", cnt, 0);
    chk("R11 reset chain cnt", ch_cnt, 0);
    rst_n = 1'b1;

    sweep_single();
    sweep_chain();

    // R5 up counting on the single slice
    @(negedge clk);
    op = 3'd3; en = 1'b1; cin = 1'b1; #1;
    chk("R7 count res shows cnt", res, 0);
    for (int s = 1; s <= 6; s++) begin
      @(negedge clk);
      chk("R5 up value", cnt, s & 3);
      chk("R5 up wrap cout", cout, int'((s & 3) == 3));
      chk("R7 res equals cnt", res, s & 3);
    end
    // now cnt = 2; R7 holds
    en = 1'b0;
    @(negedge clk); chk("R7 hold en=0", cnt, 2);
    en = 1'b1; cin = 1'b0; #1;
    chk("R5 cout needs cin", cout, 0);
    @(negedge clk); chk("R7 hold cin=0", cnt, 2);
    cin = 1'b1; op = 3'd0; a = 2'd3; b = 2'd1;
    @(negedge clk); chk("R7 hold other op", cnt, 2);
    // R6 down counting
    op = 3'd4;
    for (int s = 1; s <= 5; s++) begin
      @(negedge clk);
      chk("R6 down value", cnt, (2 - s) & 3);
      chk("R6 down wrap cout", cout, int'(((2 - s) & 3) == 0));
    end
    op = 3'd0; en = 1'b0;

    // R12 wide counter
    ch_a = '0; ch_b = '0;
    @(negedge clk);
    ch_op = 3'd3; ch_en = 1'b1; ch_c0 = 1'b1;
    for (int s = 1; s <= 260; s++) begin
      @(negedge clk);
      chk("R12 R5 wide up count", int'(ch_cnt), s & 255);
      chk("R12 wide up carry", int'(ch_c[NS]), int'((s & 255) == 255));
    end
    ch_op = 3'd4;
    for (int s = 1; s <= 10; s++) begin
      @(negedge clk);
      chk("R12 R6 wide down count", int'(ch_cnt), (4 - s) & 255);
    end
    ch_en = 1'b0;
    @(negedge clk);
    chk("R12 R7 wide hold", int'(ch_cnt), (4 - 10) & 255);

    finish_run();
  end

endmodule